// File: doc/BRIEF.md
# PLL Lock Delay Sequencer

This block decides when a phase-locked loop's output may be treated as locked. The lock decision comes from a timed wait, not from a phase detector. A programmable down-counter advances once per slow-clock period. Software programs a multiplier value, a lock count, an enable and an interrupt enable through a small register write port. The block starts a wait of a fixed number of slow-clock periods whenever the PLL is switched on or its settings change. It declares lock only when that wait has expired and the main oscillator reports that it is stable.

While lock is low, a bypass output tells the clock mux to route the reference clock around the PLL. Downstream logic therefore never sees a clock whose frequency is still settling. When lock rises, a single-cycle interrupt pulse can be raised. The block runs entirely on the system clock. Slow-clock periods arrive as a one-cycle strobe, `slow_tick`.

Top module: `pll_lock_seq`

## Requirements
- R1: With a programmed lock count n of 1 or more and the oscillator stable, LOCK rises on exactly the (n+1)-th slow tick after the sequence starts.
- R2: A programmed lock count of 0 behaves like 1, so LOCK rises on the 2nd slow tick.
- R3: `lock_irq` is high for exactly one cycle, in the same cycle that LOCK first reads 1. It is produced only when the interrupt-enable bit (bit 1 of register 0) is set.
- R4: Writing the multiplier (register 1) while the PLL is enabled clears LOCK in the next cycle and restarts the full count.
- R5: Writing the lock count (register 2) while the PLL is enabled clears LOCK and restarts the count using the newly written value.
- R6: `bypass` is high exactly when LOCK is low.
- R7: If the count expires while `osc_stable` is low, LOCK stays low. LOCK rises in the cycle after `osc_stable` is first sampled high.
- R8: Writing 0 to the enable bit (bit 0 of register 0) clears LOCK and halts counting. While disabled, slow ticks and register writes start no sequence. Writing enable 1 from the disabled state reloads the count from the programmed value.
- R9: A slow tick that arrives in the same cycle as a restarting write is not counted.
- R10: The read port returns the following, each zero-extended. Address 0 gives {irq enable, enable} in bits 1:0. Address 1 gives the multiplier. Address 2 gives the lock count exactly as written. Address 3 gives LOCK in bit 0. `pll_mul` always shows the programmed multiplier.
- R11: After reset, LOCK, `lock_irq`, the enable bits, the multiplier and the lock count are 0, and `bypass` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| osc_stable | input | 1 | Main oscillator is stable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 multiplier, 2 lock count |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read select, 0 to 3 |
| rd_data | output | DATA_W | Read data, combinational |
| pll_mul | output | MUL_W | Multiplier value driven to the PLL |
| lock | output | 1 | Lock status |
| lock_irq | output | 1 | Lock interrupt pulse |
| bypass | output | 1 | Route the reference clock around the PLL |

## Verification
On every cycle, the assertions check the following:
- the interrupt pulse coincides with a rising LOCK and lasts one cycle;
- any disable or restarting write drops LOCK in the next cycle;
- LOCK never rises unless the oscillator was stable;
- the counter loads the effective, non-zero count;
- the counter only steps down on an accepted tick.

The exact number of ticks to lock for different counts, the write-versus-tick priority, the interrupt gating and the oscillator wait can only be shown by the bench's scenarios. There, a behavioural model follows the block cycle by cycle.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_COUNT   = 2'd1,
        ST_WAITOSC = 2'd2,
        ST_LOCKED  = 2'd3
    } lk_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MUL  = 2'd1;
    localparam logic [1:0] SEL_LCNT = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

endpackage

// File: rtl/pll_lock_regs.sv
module pll_lock_regs
    import pll_lock_pkg::*;
#(
    parameter int MUL_W  = 11,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              lock,
    output logic [DATA_W-1:0] rd_data,
    output logic              en,
    output logic              irq_en,
    output logic [MUL_W-1:0]  mul,
    output logic              restart,
    output logic              stop,
    output logic [CNT_W-1:0]  load_val
);

    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic             irq_en;
        logic [MUL_W-1:0] mul;
        logic [CNT_W-1:0] lcnt;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        restart = 1'b0;
        stop    = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                SEL_CTRL: begin
                    r_d.en     = wr_data[0];
                    r_d.irq_en = wr_data[1];
                    restart    = wr_data[0] & ~r_q.en;
                    stop       = ~wr_data[0];
                end
                SEL_MUL: begin
                    r_d.mul = wr_data[MUL_W-1:0];
                    restart = r_q.en;
                end
                SEL_LCNT: begin
                    r_d.lcnt = wr_data[CNT_W-1:0];
                    restart  = r_q.en;
                end
                default: ;
            endcase
        end
        load_val = (r_d.lcnt == '0) ? MIN_CNT : r_d.lcnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            SEL_CTRL: rd_data[1:0]       = {r_q.irq_en, r_q.en};
            SEL_MUL:  rd_data[MUL_W-1:0] = r_q.mul;
            SEL_LCNT: rd_data[CNT_W-1:0] = r_q.lcnt;
            default:  rd_data[0]         = lock;
        endcase
    end

    assign en     = r_q.en;
    assign irq_en = r_q.irq_en;
    assign mul    = r_q.mul;

    // R2: the value handed to the counter is never zero
    a_r2_nonzero_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> load_val != '0);

    // R8: no sequence starts while the enable bit stays low
    a_r8_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(wr_en && wr_addr == SEL_CTRL)) |-> !restart);

endmodule

// File: rtl/pll_lock_counter.sv
module pll_lock_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             step;

    always_comb begin
        step    = run & tick & ~load;
        expired = step & (cnt_q == '0);
        cnt_d   = cnt_q;
        if (load)                      cnt_d = load_val;
        else if (step && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a restart loads the programmed count
    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

    // R9: without a load or an accepted tick the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cnt_q));

    // R1: one accepted tick removes exactly one from a non-zero count
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stop,
    input  logic expired,
    input  logic osc_stable,
    input  logic irq_en,
    output logic counting,
    output logic lock,
    output logic lock_irq
);

    typedef struct packed {
        lk_state_e st;
        logic      lock;
        logic      irq;
    } fsm_s;

    fsm_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (stop) begin
            f_d.st = ST_OFF;
        end else if (restart) begin
            f_d.st = ST_COUNT;
        end else begin
            case (f_q.st)
                ST_COUNT:   if (expired) f_d.st = osc_stable ? ST_LOCKED : ST_WAITOSC;
                ST_WAITOSC: if (osc_stable) f_d.st = ST_LOCKED;
                default: ;
            endcase
        end
        f_d.lock = (f_d.st == ST_LOCKED);
        f_d.irq  = f_d.lock & ~f_q.lock & irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '{st: ST_OFF, lock: 1'b0, irq: 1'b0};
        else        f_q <= f_d;
    end

    assign counting = (f_q.st == ST_COUNT);
    assign lock     = f_q.lock;
    assign lock_irq = f_q.irq;

    // R3: the pulse marks a rising LOCK
    a_r3_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.irq |-> (f_q.lock && !$past(f_q.lock)));

    // R3: the pulse lasts one cycle
    a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.irq |=> !f_q.irq);

    // R8: a disable drops LOCK
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!f_q.lock && f_q.st == ST_OFF));

    // R4: a restart drops LOCK
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !f_q.lock);

    // R7: LOCK only rises after a stable oscillator
    a_r7_osc_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.lock) |-> $past(osc_stable));

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
    import pll_lock_pkg::*;
#(
    parameter int MUL_W  = 11,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              osc_stable,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [MUL_W-1:0]  pll_mul,
    output logic              lock,
    output logic              lock_irq,
    output logic              bypass
);

    logic             en, irq_en, restart, stop, counting, expired;
    logic [CNT_W-1:0] load_val;

    pll_lock_regs #(.MUL_W(MUL_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .lock     (lock),
        .rd_data  (rd_data),
        .en       (en),
        .irq_en   (irq_en),
        .mul      (pll_mul),
        .restart  (restart),
        .stop     (stop),
        .load_val (load_val)
    );

    pll_lock_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .load_val (load_val),
        .run      (counting),
        .tick     (slow_tick),
        .expired  (expired)
    );

    pll_lock_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .stop       (stop),
        .expired    (expired),
        .osc_stable (osc_stable),
        .irq_en     (irq_en),
        .counting   (counting),
        .lock       (lock),
        .lock_irq   (lock_irq)
    );

    assign bypass = ~lock;

    // R8: a disabled PLL is never reported locked
    a_r8_off_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !lock);

endmodule

// File: tb/test_pll_lock_seq.sv
module test_pll_lock_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MUL_W  = 11;
    localparam int CNT_W  = 6;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slow_tick = 1'b0;
    logic              osc_stable = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = 2'd0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        rd_addr = 2'd3;
    logic [DATA_W-1:0] rd_data;
    logic [MUL_W-1:0]  pll_mul;
    logic              lock, lock_irq, bypass;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen = 0;
    string cur_req = "R11";

    pll_lock_seq #(.MUL_W(MUL_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_pll_lock_seq (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .osc_stable(osc_stable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pll_mul(pll_mul), .lock(lock), .lock_irq(lock_irq),
        .bypass(bypass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: 0 off, 1 counting, 2 waiting oscillator, 3 locked
    int m_state = 0, m_rem = 0, m_en = 0, m_irqen = 0, m_mul = 0, m_lc = 0;
    bit m_lock = 0, m_irq = 0;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_en = 0; m_irqen = 0; m_mul = 0; m_lc = 0;
            m_lock = 0; m_irq = 0;
        end else begin
            automatic bit old_lock = m_lock;
            automatic int old_irqen = m_irqen;
            automatic bit touched = 0;
            if (wr_en) begin
                if (wr_addr == 2'd0) begin
                    m_irqen = wr_data[1];
                    if (!wr_data[0]) begin m_en = 0; m_state = 0; touched = 1; end
                    else if (m_en == 0) begin
                        m_en = 1; m_state = 1; m_rem = eff(m_lc); touched = 1;
                    end
                end else if (wr_addr == 2'd1) begin
                    m_mul = wr_data[MUL_W-1:0];
                    if (m_en != 0) begin m_state = 1; m_rem = eff(m_lc); touched = 1; end
                end else if (wr_addr == 2'd2) begin
                    m_lc = wr_data[CNT_W-1:0];
                    if (m_en != 0) begin m_state = 1; m_rem = eff(m_lc); touched = 1; end
                end
            end
            if (!touched) begin
                if (m_state == 1 && slow_tick) begin
                    if (m_rem == 0) m_state = osc_stable ? 3 : 2;
                    else m_rem--;
                end else if (m_state == 2 && osc_stable) m_state = 3;
            end
            m_lock = (m_state == 3);
            m_irq  = m_lock && !old_lock && (old_irqen != 0);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            automatic int exp_rd;
            case (rd_addr)
                2'd0: exp_rd = m_irqen * 2 + m_en;
                2'd1: exp_rd = m_mul;
                2'd2: exp_rd = m_lc;
                default: exp_rd = m_lock;
            endcase
            check(cur_req, "lock", lock, m_lock);
            check("R3", "lock_irq", lock_irq, m_irq);
            check("R6", "bypass", bypass, !m_lock);
            check("R10", "pll_mul", pll_mul, m_mul);
            check("R10", "rd_data", rd_data, exp_rd);
            if (lock_irq) irq_seen++;
        end
    end

    task automatic write(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[DATA_W-1:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tick();
        slow_tick = 1'b1;
        @(posedge clk); #1;
        slow_tick = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic ticks_to_lock(input int limit, output int k);
        k = 0;
        while (!lock && k < limit) begin
            tick();
            k++;
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int k, irq0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "lock after reset", lock, 0);
        check("R11", "bypass after reset", bypass, 1);
        check("R11", "irq after reset", lock_irq, 0);
        @(posedge clk); #1;

        // R10 and R8: program while disabled, ticks start nothing
        cur_req = "R8";
        write(1, 'h155);
        write(2, 3);
        rd_addr = 2'd1; @(negedge clk); check("R10", "mul readback", rd_data, 'h155);
        rd_addr = 2'd2; @(negedge clk); check("R10", "lcnt readback", rd_data, 3);
        rd_addr = 2'd3; @(posedge clk); #1;
        repeat (6) tick();
        check("R8", "lock while disabled", lock, 0);

        // R1 and R3: enable with interrupt, n=3 gives 4 ticks
        cur_req = "R1";
        irq0 = irq_seen;
        write(0, 3);
        rd_addr = 2'd0; @(negedge clk); check("R10", "ctrl readback", rd_data, 3);
        rd_addr = 2'd3; @(posedge clk); #1;
        ticks_to_lock(200, k);
        check("R1", "ticks for n=3", k, 4);
        repeat (2) @(posedge clk); #1;
        check("R3", "irq pulses on lock", irq_seen - irq0, 1);
        tick();
        check("R1", "lock holds on later ticks", lock, 1);

        // R4: multiplier write while locked restarts
        cur_req = "R4";
        write(1, 'h2AA);
        check("R4", "lock cleared after mul write", lock, 0);
        ticks_to_lock(200, k);
        check("R4", "ticks after mul write", k, 4);

        // R5: new lock count while locked
        cur_req = "R5";
        write(2, 5);
        check("R5", "lock cleared after lcnt write", lock, 0);
        ticks_to_lock(200, k);
        check("R5", "ticks for n=5", k, 6);

        // R2: zero and one both give 2 ticks
        cur_req = "R2";
        write(2, 0);
        ticks_to_lock(200, k);
        check("R2", "ticks for n=0", k, 2);
        write(2, 1);
        ticks_to_lock(200, k);
        check("R2", "ticks for n=1", k, 2);

        // R1 boundary: largest count
        cur_req = "R1";
        write(2, 63);
        ticks_to_lock(200, k);
        check("R1", "ticks for n=63", k, 64);

        // R9: tick in the same cycle as the restarting write is not counted
        cur_req = "R9";
        slow_tick = 1'b1;
        write(2, 2);
        slow_tick = 1'b0;
        @(posedge clk); #1;
        ticks_to_lock(200, k);
        check("R9", "ticks after write with tick", k, 3);

        // R7: count expires with oscillator unstable
        cur_req = "R7";
        osc_stable = 1'b0;
        write(1, 'h011);
        repeat (10) tick();
        check("R7", "no lock without oscillator", lock, 0);
        osc_stable = 1'b1;
        @(posedge clk); #1;
        check("R7", "lock one cycle after oscillator", lock, 1);

        // R8 and R3: disable, then re-enable with interrupt off
        cur_req = "R8";
        write(0, 2);
        check("R8", "lock cleared on disable", lock, 0);
        check("R6", "bypass on disable", bypass, 1);
        write(2, 4);
        repeat (8) tick();
        check("R8", "no lock after writes while disabled", lock, 0);
        irq0 = irq_seen;
        write(0, 1);
        ticks_to_lock(200, k);
        check("R8", "ticks after re-enable", k, 5);
        repeat (2) @(posedge clk); #1;
        check("R3", "no irq when disabled", irq_seen - irq0, 0);

        repeat (3) @(posedge clk);
        finish_up();
    end

endmodule